// File: doc/BRIEF.md
# External Bus Cycle Sequencer with Wait States

This block runs one processor-side access to external memory at a time. It turns a request (direction, address, memory-space code and write data) into a four-phase bus cycle on the pins. Phase 1 puts out the address, the space select lines and the read/write direction. The transfer strobe rises in phase 2 and falls in phase 4. Between phase 3 and phase 4 the sequencer repeats a wait phase for as long as the cycle has to be stretched.

The stretch is the longer of two delays. One is a wait count that the requester copies from its bus control register when the request is taken. The other is the time until the external memory raises its transfer acknowledge. The acknowledge is looked at only while the strobe is active. For a read, the data bus is captured on the edge where the strobe falls. For a write, the data driver is enabled only while the strobe is active. Between cycles the space lines are released and the data bus is not driven. The address stays where it was, so that the address pins do not toggle and waste power.

A new request is taken when the bus is idle or when a cycle is in phase 4. This allows back-to-back cycles with no gap between them.

Top module: `ext_bus_seq`

## Requirements
- R1: The strobe `bus_strobe_o` (1 = active) first goes high in phase 2, the second clock after the request is accepted. When it rises, `bus_addr_o` and `bus_space_o` are unchanged from phase 1 and `bus_space_o` is nonzero.
- R2: With a wait count of 0 and acknowledge high in phase 3, the strobe is high for exactly two clocks (phases 2 and 3). In phase 4, the fourth clock after acceptance, it is low and `done_o` is high for one clock.
- R3: Strobe clocks from phase 3 onward are numbered t = 0, 1, 2, … The cycle leaves the strobe at the first t with t >= N where `xfer_ack_i` is high at that clock edge, with N the loaded wait count. The strobe therefore stays high for W = t extra clocks. An acknowledge seen while t < N is not remembered.
- R4: N is taken from `bcr_wait_i` on the edge that accepts the request. Changes to `bcr_wait_i` after that have no effect on the running cycle.
- R5: On a read, `rd_data_o` takes the value of `bus_data_i` sampled on the edge where the strobe falls. `rd_valid_o` is high for exactly the phase-4 clock of a read.
- R6: `bus_addr_o` changes only on an accepting edge. It holds its value through phase 4 and through any idle clocks that follow.
- R7: While idle, `bus_space_o` is 0, `bus_data_oe_o` is 0 and `bus_rw_o` is 1. After reset, `bus_addr_o` is 0.
- R8: `bus_rw_o` is 1 for a read and 0 for a write. It is valid from phase 1 through phase 4, so it is already settled when the strobe rises.
- R9: On a write, `bus_data_oe_o` is high exactly on the strobe-high clocks and `bus_data_o` equals the write data of the request. On a read, `bus_data_oe_o` stays 0.
- R10: `req_i` is accepted only in idle or phase 4. In phases 1, 2, 3 and in wait phases it is ignored, and the running cycle and the address pins are unchanged.
- R11: A request held high during phase 4 starts phase 1 on the next clock, with no idle clock in between.
- R12: `xfer_ack_i` has no effect outside strobe-high clocks. An acknowledge held high in idle, phase 1, phase 2 or phase 4 neither shortens nor ends a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a bus cycle (taken in idle or phase 4) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Address of the access |
| req_space_i | input | SPW | Memory-space select code, nonzero |
| req_wdata_i | input | DW | Write data |
| bcr_wait_i | input | WW | Wait count field from the bus control register |
| xfer_ack_i | input | 1 | Transfer acknowledge from memory (active high by default) |
| bus_data_i | input | DW | Data bus as seen at the pins |
| bus_addr_o | output | AW | Address pins, held between cycles |
| bus_space_o | output | SPW | Memory-space select lines, 0 when idle |
| bus_strobe_o | output | 1 | Transfer strobe (active high by default) |
| bus_rw_o | output | 1 | Direction: 1 read, 0 write (default polarity) |
| bus_data_o | output | DW | Write data to the pins |
| bus_data_oe_o | output | 1 | Enable for the data pin driver |
| rd_data_o | output | DW | Captured read data |
| rd_valid_o | output | 1 | High in phase 4 of a read |
| done_o | output | 1 | High in phase 4 of every cycle |

## Verification
The assertions assume that the requester always gives a nonzero space code. Otherwise the space lines could not tell a live cycle from an idle bus. They also assume that the requester never changes the request fields in a way that matters outside the accepting edge, because all of them are latched on that edge. The bench keeps within these limits: every request it issues has a space code of 1, 2 or 3, and it raises `req_i` only when the bus is idle or in phase 4. The one exception is the deliberate mid-cycle pulse that tests R10. The acknowledge is driven with several patterns: a delay longer than the count, a delay shorter than the count, an early pulse that arrives before the count expires, and a level held outside the strobe window. The read data changes on every clock, so capturing it one clock early or late gives a different value.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_ONE   = 3'd1,
      PH_TWO   = 3'd2,
      PH_THREE = 3'd3,
      PH_WAIT  = 3'd4,
      PH_FOUR  = 3'd5
   } ebs_phase_e;

   // Phases in which the transfer strobe is active.
   function automatic logic strobe_phase(ebs_phase_e p);
      return (p == PH_TWO) || (p == PH_THREE) || (p == PH_WAIT);
   endfunction

   // Phases in which a new request may be taken.
   function automatic logic accept_phase(ebs_phase_e p);
      return (p == PH_IDLE) || (p == PH_FOUR);
   endfunction

endpackage

// File: rtl/ebs_wait_ctr.sv
module ebs_wait_ctr #(
   parameter int WW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [WW-1:0] load_val_i,
   input  logic          tick_i,
   output logic          zero_o
);

   logic [WW-1:0] cnt_q;

   // Loaded at acceptance, counts down once per strobe clock, stops at zero.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (tick_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

   p_load_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(load_val_i)));

   p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && zero_o && !load_i) |=> zero_o);

   p_one_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !zero_o && !load_i) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ebs_phase_seq.sv
module ebs_phase_seq
   import ebs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req_i,
   input  logic       ack_i,
   input  logic       cnt_zero_i,
   output ebs_phase_e phase_o,
   output logic       accept_o,
   output logic       tick_o,
   output logic       finish_o
);

   ebs_phase_e ph_q;
   ebs_phase_e ph_d;

   assign accept_o = req_i && accept_phase(ph_q);
   assign tick_o   = (ph_q == PH_THREE) || (ph_q == PH_WAIT);
   assign finish_o = tick_o && cnt_zero_i && ack_i;

   always_comb begin
      ph_d = ph_q;
      unique case (ph_q)
         PH_IDLE:           ph_d = accept_o ? PH_ONE : PH_IDLE;
         PH_ONE:            ph_d = PH_TWO;
         PH_TWO:            ph_d = PH_THREE;
         PH_THREE, PH_WAIT: ph_d = finish_o ? PH_FOUR : PH_WAIT;
         PH_FOUR:           ph_d = accept_o ? PH_ONE : PH_IDLE;
         default:           ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   assign phase_o = ph_q;

   p_hold_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && !cnt_zero_i) |=> (ph_q == PH_WAIT));

   p_wait_for_ack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && !ack_i) |=> (ph_q == PH_WAIT));

   p_ignore_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !accept_o |=> (ph_q != PH_ONE));

   p_back_to_back_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ((ph_q == PH_FOUR) && req_i) |=> (ph_q == PH_ONE));

   p_fixed_lead_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_ONE) |=> (ph_q == PH_TWO));

endmodule

// File: rtl/ebs_pin_drv.sv
module ebs_pin_drv
   import ebs_pkg::*;
#(
   parameter int AW           = 16,
   parameter int SPW          = 2,
   parameter bit STROBE_LOW   = 1'b0,
   parameter bit RW_READ_HIGH = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  ebs_phase_e     phase_i,
   input  logic           accept_i,
   input  logic           write_i,
   input  logic [AW-1:0]  addr_i,
   input  logic [SPW-1:0] space_i,
   output logic [AW-1:0]  bus_addr_o,
   output logic [SPW-1:0] bus_space_o,
   output logic           bus_strobe_o,
   output logic           bus_rw_o,
   output logic           wr_q_o
);

   logic [AW-1:0]  addr_q;
   logic [SPW-1:0] space_q;
   logic           wr_q;
   logic           strobe_act;
   logic           live;
   logic           read_level;

   // Request fields are latched only on an accepting edge; the address is
   // never cleared, so it stays on the pins between cycles.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         space_q <= '0;
         wr_q    <= 1'b0;
      end else if (accept_i) begin
         addr_q  <= addr_i;
         space_q <= space_i;
         wr_q    <= write_i;
      end
   end

   assign strobe_act  = strobe_phase(phase_i);
   assign live        = (phase_i != PH_IDLE);
   assign bus_addr_o  = addr_q;
   assign bus_space_o = live ? space_q : '0;
   assign read_level  = live ? ~wr_q : 1'b1;
   assign wr_q_o      = wr_q;

   if (STROBE_LOW) begin : g_strobe_low
      assign bus_strobe_o = ~strobe_act;
   end else begin : g_strobe_high
      assign bus_strobe_o = strobe_act;
   end

   if (RW_READ_HIGH) begin : g_rw_read_high
      assign bus_rw_o = read_level;
   end else begin : g_rw_read_low
      assign bus_rw_o = ~read_level;
   end

   p_strobe_qualified_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_act) |-> ($stable(bus_addr_o) && $stable(bus_space_o)
                             && (bus_space_o != '0)));

   p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !accept_i |=> $stable(bus_addr_o));

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_i == PH_IDLE) |-> ((bus_space_o == '0) && read_level));

   p_rw_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe_act) |-> ($stable(read_level) && (read_level == ~wr_q)));

endmodule

// File: rtl/ebs_data_path.sv
module ebs_data_path
   import ebs_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ebs_phase_e    phase_i,
   input  logic          accept_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          wr_q_i,
   input  logic          finish_i,
   input  logic [DW-1:0] bus_data_i,
   output logic [DW-1:0] bus_data_o,
   output logic          bus_data_oe_o,
   output logic [DW-1:0] rd_data_o,
   output logic          rd_valid_o
);

   logic [DW-1:0] wdata_q;
   logic [DW-1:0] rdata_q;
   logic          rvalid_q;
   logic          capture;

   assign capture = finish_i && !wr_q_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wdata_q <= '0;
      end else if (accept_i) begin
         wdata_q <= wdata_i;
      end
   end

   // Read data is taken on the same edge that drops the strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= capture;
         if (capture) rdata_q <= bus_data_i;
      end
   end

   assign bus_data_o    = wdata_q;
   assign bus_data_oe_o = wr_q_i && strobe_phase(phase_i);
   assign rd_data_o     = rdata_q;
   assign rd_valid_o    = rvalid_q;

   p_capture_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (rd_data_o == $past(bus_data_i)) && rd_valid_o);

   p_oe_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_data_oe_o) |-> (phase_i == PH_FOUR));

   p_read_undriven_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> !$past(bus_data_oe_o));

   p_wdata_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_data_oe_o |-> $stable(bus_data_o));

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
   import ebs_pkg::*;
#(
   parameter int AW           = 16,
   parameter int DW           = 32,
   parameter int WW           = 4,
   parameter int SPW          = 2,
   parameter bit STROBE_LOW   = 1'b0,
   parameter bit ACK_LOW      = 1'b0,
   parameter bit RW_READ_HIGH = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           req_i,
   input  logic           req_write_i,
   input  logic [AW-1:0]  req_addr_i,
   input  logic [SPW-1:0] req_space_i,
   input  logic [DW-1:0]  req_wdata_i,
   input  logic [WW-1:0]  bcr_wait_i,
   input  logic           xfer_ack_i,
   input  logic [DW-1:0]  bus_data_i,
   output logic [AW-1:0]  bus_addr_o,
   output logic [SPW-1:0] bus_space_o,
   output logic           bus_strobe_o,
   output logic           bus_rw_o,
   output logic [DW-1:0]  bus_data_o,
   output logic           bus_data_oe_o,
   output logic [DW-1:0]  rd_data_o,
   output logic           rd_valid_o,
   output logic           done_o
);

   localparam logic STROBE_IDLE_LVL = STROBE_LOW;
   localparam int   MAX_WAIT        = (1 << WW) - 1;

   if (AW < 1) begin : g_bad_aw
      $error("ext_bus_seq: AW must be at least 1");
   end
   if (DW < 1) begin : g_bad_dw
      $error("ext_bus_seq: DW must be at least 1");
   end
   if ((WW < 1) || (WW > 16)) begin : g_bad_ww
      $error("ext_bus_seq: WW must lie in 1..16");
   end
   if (SPW < 1) begin : g_bad_spw
      $error("ext_bus_seq: SPW must be at least 1");
   end
   if (MAX_WAIT < 1) begin : g_bad_wait
      $error("ext_bus_seq: wait range is empty");
   end

   logic       ack_seen;
   ebs_phase_e phase;
   logic       accept;
   logic       tick;
   logic       finish;
   logic       cnt_zero;
   logic       wr_q;

   if (ACK_LOW) begin : g_ack_low
      assign ack_seen = ~xfer_ack_i;
   end else begin : g_ack_high
      assign ack_seen = xfer_ack_i;
   end

   ebs_phase_seq u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_i      (req_i),
      .ack_i      (ack_seen),
      .cnt_zero_i (cnt_zero),
      .phase_o    (phase),
      .accept_o   (accept),
      .tick_o     (tick),
      .finish_o   (finish)
   );

   ebs_wait_ctr #(.WW(WW)) u_wait (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (accept),
      .load_val_i (bcr_wait_i),
      .tick_i     (tick),
      .zero_o     (cnt_zero)
   );

   ebs_pin_drv #(
      .AW           (AW),
      .SPW          (SPW),
      .STROBE_LOW   (STROBE_LOW),
      .RW_READ_HIGH (RW_READ_HIGH)
   ) u_pins (
      .clk          (clk),
      .rst_n        (rst_n),
      .phase_i      (phase),
      .accept_i     (accept),
      .write_i      (req_write_i),
      .addr_i       (req_addr_i),
      .space_i      (req_space_i),
      .bus_addr_o   (bus_addr_o),
      .bus_space_o  (bus_space_o),
      .bus_strobe_o (bus_strobe_o),
      .bus_rw_o     (bus_rw_o),
      .wr_q_o       (wr_q)
   );

   ebs_data_path #(.DW(DW)) u_data (
      .clk           (clk),
      .rst_n         (rst_n),
      .phase_i       (phase),
      .accept_i      (accept),
      .wdata_i       (req_wdata_i),
      .wr_q_i        (wr_q),
      .finish_i      (finish),
      .bus_data_i    (bus_data_i),
      .bus_data_o    (bus_data_o),
      .bus_data_oe_o (bus_data_oe_o),
      .rd_data_o     (rd_data_o),
      .rd_valid_o    (rd_valid_o)
   );

   assign done_o = (phase == PH_FOUR);

   p_zero_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ((phase == PH_THREE) && cnt_zero && ack_seen)
      |=> ((bus_strobe_o == STROBE_IDLE_LVL) && done_o));

   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !req_i) |=> !done_o);

   p_ack_outside_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ((bus_strobe_o == STROBE_IDLE_LVL) && !done_o) |=> !done_o);

endmodule

// File: tb/ext_bus_seq_bench.sv
`timescale 1ns/1ps
module ext_bus_seq_bench;

   localparam int AW  = 16;
   localparam int DW  = 32;
   localparam int WW  = 4;
   localparam int SPW = 2;
   localparam int WATCHDOG = 100000;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           req = 1'b0;
   logic           req_wr = 1'b0;
   logic [AW-1:0]  req_addr = '0;
   logic [SPW-1:0] req_space = '0;
   logic [DW-1:0]  req_wdata = '0;
   logic [WW-1:0]  bcr = '0;
   logic           ack = 1'b0;
   logic [DW-1:0]  din = '0;

   logic [AW-1:0]  bus_addr;
   logic [SPW-1:0] bus_space;
   logic           bus_strobe;
   logic           bus_rw;
   logic [DW-1:0]  bus_dout;
   logic           bus_oe;
   logic [DW-1:0]  rd_data;
   logic           rd_valid;
   logic           done;

   ext_bus_seq u_ext_bus_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_i         (req),
      .req_write_i   (req_wr),
      .req_addr_i    (req_addr),
      .req_space_i   (req_space),
      .req_wdata_i   (req_wdata),
      .bcr_wait_i    (bcr),
      .xfer_ack_i    (ack),
      .bus_data_i    (din),
      .bus_addr_o    (bus_addr),
      .bus_space_o   (bus_space),
      .bus_strobe_o  (bus_strobe),
      .bus_rw_o      (bus_rw),
      .bus_data_o    (bus_dout),
      .bus_data_oe_o (bus_oe),
      .rd_data_o     (rd_data),
      .rd_valid_o    (rd_valid),
      .done_o        (done)
   );

   always #2 clk = ~clk;

   // Reference model state. Phase codes: 0 idle, 1..4 phases, 5 wait.
   int             m_ph = 0;
   int             m_cnt = 0;
   int             m_ticks = 0;
   logic [AW-1:0]  m_addr = '0;
   logic [SPW-1:0] m_space = '0;
   bit             m_wr = 1'b0;
   logic [DW-1:0]  m_wdata = '0;
   logic [DW-1:0]  m_rdata = '0;

   // Acknowledge pattern knobs.
   int  ack_delay = 0;
   bit  ack_early = 1'b0;
   bit  ack_outside = 1'b0;

   int  vectors = 0;
   int  misses = 0;
   int  cyc = 0;
   bit  finished = 1'b0;

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   endtask

   // Model update on the clock edge from the inputs held since the last falling edge.
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_ticks = 0;
         m_addr = '0; m_space = '0; m_wr = 1'b0; m_wdata = '0; m_rdata = '0;
      end else begin
         if ((m_ph == 0 || m_ph == 4) && req) begin
            m_ph = 1; m_addr = req_addr; m_space = req_space; m_wr = req_wr;
            m_wdata = req_wdata; m_cnt = int'(bcr); m_ticks = 0;
         end else if (m_ph == 0 || m_ph == 4) begin
            m_ph = 0;
         end else if (m_ph == 1) begin
            m_ph = 2;
         end else if (m_ph == 2) begin
            m_ph = 3;
         end else begin
            if (m_cnt == 0 && ack) begin
               m_ph = 4;
               if (!m_wr) m_rdata = din;
            end else begin
               if (m_cnt > 0) m_cnt--;
               m_ph = 5;
            end
            m_ticks++;
         end
      end
   end

   // Compare on the falling edge, then drive the memory-side inputs.
   always @(negedge clk) begin
      if (rst_n) begin
         bit strobe_exp;
         strobe_exp = (m_ph == 2 || m_ph == 3 || m_ph == 5);
         chk("R1/R2/R3 strobe", 64'(bus_strobe), 64'(strobe_exp));
         chk("R1/R7 space", 64'(bus_space), 64'((m_ph != 0) ? m_space : '0));
         chk("R6 address", 64'(bus_addr), 64'(m_addr));
         chk("R8 direction", 64'(bus_rw), 64'((m_ph != 0) ? !m_wr : 1'b1));
         chk("R9/R12 oe", 64'(bus_oe), 64'(m_wr && strobe_exp));
         if (m_wr && strobe_exp) chk("R9 write data", 64'(bus_dout), 64'(m_wdata));
         chk("R2/R11 done", 64'(done), 64'(m_ph == 4));
         chk("R5 rd_valid", 64'(rd_valid), 64'(m_ph == 4 && !m_wr));
         chk("R5 rd_data", 64'(rd_data), 64'(m_rdata));
      end
      cyc++;
      din = {cyc[15:0], ~cyc[15:0]};
      if (m_ph == 3 || m_ph == 5)
         ack = (ack_early && m_ticks == 0) || (m_ticks >= ack_delay);
      else
         ack = ack_outside;
      if (cyc > WATCHDOG && !finished) begin
         misses++;
         $display("FAIL watchdog R1..: actual=hung expected=finished");
         summary();
      end
   end

   task automatic issue(bit wr, logic [AW-1:0] a, logic [SPW-1:0] sp,
                        logic [DW-1:0] wd, int wt, int dly, bit early, bit outside);
      while (!(m_ph == 0 || m_ph == 4)) @(negedge clk);
      ack_delay = dly; ack_early = early; ack_outside = outside;
      req = 1'b1; req_wr = wr; req_addr = a; req_space = sp; req_wdata = wd;
      bcr = WW'(wt);
      @(negedge clk);
      req = 1'b0;
      bcr = ~WW'(wt);           // R4: later changes must not matter
      req_addr = ~a; req_wdata = ~wd; req_wr = ~wr;
      while (m_ph != 4) @(negedge clk);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      // Reset state, checked while reset is held (R7).
      repeat (3) @(negedge clk);
      chk("R7 reset strobe", 64'(bus_strobe), 64'(0));
      chk("R7 reset space", 64'(bus_space), 64'(0));
      chk("R7 reset oe", 64'(bus_oe), 64'(0));
      chk("R7 reset rw", 64'(bus_rw), 64'(1));
      chk("R7 reset addr", 64'(bus_addr), 64'(0));
      chk("R7 reset done", 64'(done), 64'(0));
      rst_n = 1'b1;
      idle(3);

      // R2: zero-wait read and write.
      issue(1'b0, 16'h1234, 2'd1, 32'h0, 0, 0, 1'b0, 1'b0);
      idle(2);
      issue(1'b1, 16'h00F0, 2'd2, 32'hCAFE_0001, 0, 0, 1'b0, 1'b0);
      idle(3);
      // R3: counter longer than acknowledge delay.
      issue(1'b0, 16'h2222, 2'd3, 32'h0, 3, 0, 1'b0, 1'b0);
      idle(1);
      // R3: acknowledge later than counter.
      issue(1'b0, 16'h3333, 2'd1, 32'h0, 1, 4, 1'b0, 1'b0);
      idle(1);
      // R3/R9: equal delays on a write.
      issue(1'b1, 16'h4444, 2'd2, 32'hDEAD_BEEF, 2, 2, 1'b0, 1'b0);
      idle(2);
      // R3: early acknowledge pulse while counter still running is not kept.
      issue(1'b0, 16'h5555, 2'd1, 32'h0, 2, 4, 1'b1, 1'b0);
      idle(2);
      // R12: acknowledge held outside the strobe window.
      issue(1'b0, 16'h6666, 2'd3, 32'h0, 0, 2, 1'b0, 1'b1);
      idle(4);
      ack_outside = 1'b0;
      // R11: back-to-back cycles from phase 4.
      issue(1'b0, 16'h7001, 2'd1, 32'h0, 0, 0, 1'b0, 1'b0);
      issue(1'b1, 16'h7002, 2'd2, 32'h1111_2222, 1, 0, 1'b0, 1'b0);
      issue(1'b0, 16'h7003, 2'd3, 32'h0, 0, 1, 1'b0, 1'b0);
      idle(3);
      // R10: a request pulse in phase 2 is ignored.
      while (m_ph != 0) @(negedge clk);
      ack_delay = 2; ack_early = 1'b0;
      req = 1'b1; req_wr = 1'b0; req_addr = 16'h8888; req_space = 2'd1; bcr = 4'd1;
      @(negedge clk);
      req = 1'b0;
      @(negedge clk);
      req = 1'b1; req_wr = 1'b1; req_addr = 16'h9999; req_space = 2'd2; bcr = 4'd0;
      @(negedge clk);
      req = 1'b0;
      while (m_ph != 4) @(negedge clk);
      idle(3);
      // R3: longest wait count on a write.
      issue(1'b1, 16'hABCD, 2'd2, 32'h5A5A_A5A5, 15, 0, 1'b0, 1'b0);
      idle(2);
      // Mixed sweep.
      for (int i = 0; i < 20; i++) begin
         issue(bit'(i % 2), AW'(16'h1000 + i * 37), SPW'(1 + (i % 3)),
               DW'(32'h0100_0000 * i + i), i % 5, (i * 3) % 7, bit'(i % 4 == 1),
               bit'(i % 3 == 2));
         if (i % 3 == 0) idle(i % 4);
      end
      ack_outside = 1'b0;
      idle(5);
      summary();
   end

endmodule